// File: doc/BRIEF.md
# Area-Based External Bus Controller

This block turns one internal bus request at a time (a 24-bit address, a read or write flag, a byte or word size and write data) into a timed cycle on an external memory bus. The external address space is cut into eight equal 2 MB areas. The three top address bits pick the area, and each area has its own active-low chip select. Each area carries its own settings: an 8-bit or 16-bit data bus, 2-state or 3-state basic timing, a count of programmed wait states, optional chip-select extension states, and an option that keeps the read strobe low for longer.

One bus state lasts one clock. A requester raises `req_valid` while `req_ready` is high. It then waits for the one-clock `req_done` pulse, which carries the read result. The area settings are taken from the configuration inputs when the request is accepted. An external wait input can stretch 3-state cycles. A word access to an 8-bit area is run as two byte cycles, and the requester sees only one completion.

Top module: `ext_area_bus_ctrl`

## Requirements
- R1: While reset is held, and in the first clock after it, all chip selects, `bus_rd_n`, `bus_wrh_n` and `bus_wrl_n` are high, `bus_doe` is 0, `req_done` is 0 and `req_ready` is 1.
- R2: The area index is `req_addr[23:21]`. Only `bus_cs_n[index]` goes low, and it stays low for exactly the states of that access. At most one chip select is low at any time.
- R3: When `cfg_three[i]` is 0, a cycle in area i lasts 2 states (T1, T2), read data is sampled at the end of T2, and `bus_wait_n` is ignored.
- R4: When `cfg_three[i]` is 1, a cycle lasts 3 states plus the number of programmed wait states in `cfg_waits[2i+1:2i]` (0 to 3). The wait states are inserted after T2, and read data is sampled at the end of T3.
- R5: In a 3-state area, `bus_wait_n` is sampled at the end of the state just before T3. That state is T2 when no waits are programmed, or otherwise the last programmed wait. Each low sample adds one more wait state, and the input is sampled again at the end of that state.
- R6: When `cfg_ext[i]` is 1, one state is added before the access and one after it. In both added states the chip select is low and `bus_rd_n`, `bus_wrh_n` and `bus_wrl_n` are high.
- R7: When `cfg_rd_late[i]` is 1, a read keeps `bus_rd_n` low for one state after its last access state. Without extension, that state comes after the chip select has gone high. When the option is 0, `bus_rd_n` is high in that state.
- R8: For writes, the write strobes are low only in T2 and in wait states. `bus_doe` is 1 for every state in which the chip select is low.
- R9: A word access (`req_word`=1) to an 8-bit area (`cfg_wide[i]`=0) runs two back-to-back byte cycles. The first is at the even address and carries the upper byte, `req_wdata[15:8]` or `req_rdata[15:8]`. The second is at the odd address and carries the lower byte. Both use lanes `bus_dout[15:8]`/`bus_din[15:8]` and `bus_wrh_n`, and `req_done` pulses once after the second cycle.
- R10: In a 16-bit area, a byte access at an even address uses lanes [15:8] and `bus_wrh_n`, and one at an odd address uses lanes [7:0] and `bus_wrl_n`. A word access uses both lanes and both strobes, with the address bit 0 forced to 0. Byte write data comes from `req_wdata[7:0]`, and a byte read returns `{8'h00, byte}`. Byte accesses in an 8-bit area use lanes [15:8] and `bus_wrh_n`.
- R11: `req_ready` is 1 only when no access is running. After the last state of a request, `req_done` is 1 for exactly one clock and `req_rdata` holds the read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| req_rdata | output | 16 | Read result, valid with req_done |
| req_done | output | 1 | One-clock completion pulse |
| cfg_wide | input | 8 | Per area: 1 = 16-bit bus |
| cfg_three | input | 8 | Per area: 1 = 3-state cycles |
| cfg_waits | input | 16 | Per area: 2-bit programmed wait count |
| cfg_ext | input | 8 | Per area: add extension states |
| cfg_rd_late | input | 8 | Per area: hold read strobe one extra state |
| bus_addr | output | 24 | External address |
| bus_din | input | 16 | External data in |
| bus_dout | output | 16 | External data out |
| bus_doe | output | 1 | Data output enable |
| bus_cs_n | output | 8 | Active-low area chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wrh_n | output | 1 | Active-low write strobe, lanes [15:8] |
| bus_wrl_n | output | 1 | Active-low write strobe, lanes [7:0] |
| bus_wait_n | input | 1 | Active-low external wait request |

## Verification
The bench counts the chip-select states of each access. A design that lets the wait pin affect 2-state areas, or samples it too early, would show the wrong count. So would a design that drops the release of a held wait or miscounts the programmed waits. Word accesses to an 8-bit area are checked for byte order, the even-then-odd address sequence, lane use and a single completion pulse. A design that swapped the bytes or pulsed done after each half would fail those checks. Byte lanes and strobes for odd and even addresses in a 16-bit area are checked, along with the strobe levels in the extension states and the extra read-strobe state. Each of these only shows up at the edges of a cycle.

// File: rtl/bac_pkg.sv
// Shared types for the area-based external bus controller.
// Assumes one bus state per clock and a two-lane (16-bit) external data bus.
package bac_pkg;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = 2 * BYTE_W;
    localparam int WCOUNT_W = 2;

    // Settings of one area, captured when a request is accepted.
    typedef struct packed {
        logic                wide;     // 16-bit data bus
        logic                three;    // 3-state basic cycle
        logic [WCOUNT_W-1:0] waits;    // programmed wait states
        logic                ext;      // chip-select extension states
        logic                rd_late;  // read strobe held one extra state
    } area_cfg_t;

    // Bus cycle states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_T1   = 3'd2,
        ST_T2   = 3'd3,
        ST_TW   = 3'd4,
        ST_T3   = 3'd5,
        ST_POST = 3'd6
    } bus_state_t;
endpackage

// File: rtl/bac_area_sel.sv
// Picks the settings of the addressed area out of the flat per-area configuration vectors.
// Assumes the area index is already taken from the top address bits. Purely combinational.
module bac_area_sel
    import bac_pkg::*;
#(
    parameter int N_AREAS = 8,
    localparam int AREA_W = $clog2(N_AREAS)
) (
    input  logic [AREA_W-1:0]           area_idx,
    input  logic [N_AREAS-1:0]          cfg_wide,
    input  logic [N_AREAS-1:0]          cfg_three,
    input  logic [N_AREAS*WCOUNT_W-1:0] cfg_waits,
    input  logic [N_AREAS-1:0]          cfg_ext,
    input  logic [N_AREAS-1:0]          cfg_rd_late,
    output area_cfg_t                   sel_cfg
);
    // Gather the fields of the selected area into one record.
    always_comb begin
        sel_cfg.wide    = cfg_wide[area_idx];
        sel_cfg.three   = cfg_three[area_idx];
        sel_cfg.waits   = cfg_waits[area_idx*WCOUNT_W +: WCOUNT_W];
        sel_cfg.ext     = cfg_ext[area_idx];
        sel_cfg.rd_late = cfg_rd_late[area_idx];
    end
endmodule

// File: rtl/bac_seq.sv
// Bus cycle sequencer. It steps through the extension, basic and wait states of each byte or word
// cycle and repeats the cycle for the odd byte when a word goes to an 8-bit area.
// Assumes start is only raised while idle. The area settings are captured at start.
module bac_seq
    import bac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_word,
    input  area_cfg_t  cfg_in,
    input  logic       wait_n,
    output bus_state_t state,
    output area_cfg_t  cfg_q,
    output logic       split_q,
    output logic       phase,
    output logic       cycle_end,
    output logic       done
);
    logic [WCOUNT_W-1:0] wcnt;
    logic                byte_end;
    logic                last_byte;

    // Last access state of a byte cycle, where read data is sampled.
    assign cycle_end = (state == ST_T2 && !cfg_q.three) || (state == ST_T3);
    // Final state of a byte cycle, including the trailing extension state.
    assign byte_end  = cfg_q.ext ? (state == ST_POST) : cycle_end;
    // No further byte cycle follows this one.
    assign last_byte = !split_q || phase;

    // State register, wait counter, byte phase and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            split_q <= 1'b0;
            phase   <= 1'b0;
            wcnt    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        split_q <= start_word && !cfg_in.wide;
                        phase   <= 1'b0;
                        state   <= cfg_in.ext ? ST_PRE : ST_T1;
                    end
                end
                ST_PRE:  state <= ST_T1;
                ST_T1:   state <= ST_T2;
                ST_T2: begin
                    if (cfg_q.three) begin
                        if (cfg_q.waits != '0) begin
                            wcnt  <= cfg_q.waits - 1'b1;
                            state <= ST_TW;
                        end else if (!wait_n) begin
                            wcnt  <= '0;
                            state <= ST_TW;
                        end else begin
                            state <= ST_T3;
                        end
                    end
                end
                ST_TW: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - 1'b1;
                    end else if (wait_n) begin
                        state <= ST_T3;
                    end
                end
                ST_T3:   state <= state;
                ST_POST: state <= state;
                default: state <= ST_IDLE;
            endcase
            // Leaving a byte cycle: start the odd byte, or finish the request.
            if (byte_end) begin
                if (last_byte) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    phase <= 1'b1;
                    state <= cfg_q.ext ? ST_PRE : ST_T1;
                end
            end else if (cycle_end && cfg_q.ext) begin
                state <= ST_POST;
            end
        end
    end
endmodule

// File: rtl/bac_lanes.sv
// Address and byte-lane steering. It forms the external address of the current byte cycle,
// places write data on the correct lanes, selects the write strobes and builds the read result.
// Assumes the request fields stay stable from acceptance to completion.
module bac_lanes
    import bac_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              word_q,
    input  logic              wide,
    input  logic              split,
    input  logic              phase,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] din,
    input  logic              sample,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [DATA_W-1:0] dout,
    output logic              use_hi,
    output logic              use_lo,
    output logic [DATA_W-1:0] rdata
);
    logic full_word;
    logic odd_lane;

    assign full_word = word_q && wide;
    assign odd_lane  = wide && !word_q && addr_q[0];

    // External address of the current byte or word cycle.
    always_comb begin
        if (split)          eff_addr = {addr_q[ADDR_W-1:1], phase};
        else if (full_word) eff_addr = {addr_q[ADDR_W-1:1], 1'b0};
        else                eff_addr = addr_q;
    end

    // Lane enables for the write strobes.
    assign use_hi = full_word || !odd_lane;
    assign use_lo = full_word || odd_lane;

    // Write data placed on the lanes in use.
    always_comb begin
        if (full_word)  dout = wdata_q;
        else if (split) dout = phase ? {wdata_q[BYTE_W-1:0], {BYTE_W{1'b0}}}
                                     : {wdata_q[DATA_W-1:BYTE_W], {BYTE_W{1'b0}}};
        else if (odd_lane) dout = {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]};
        else               dout = {wdata_q[BYTE_W-1:0], {BYTE_W{1'b0}}};
    end

    // Read result register, loaded at each sampling point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (sample) begin
            if (full_word)     rdata <= din;
            else if (split && !phase) rdata[DATA_W-1:BYTE_W] <= din[DATA_W-1:BYTE_W];
            else if (split)    rdata[BYTE_W-1:0] <= din[DATA_W-1:BYTE_W];
            else if (odd_lane) rdata <= {{BYTE_W{1'b0}}, din[BYTE_W-1:0]};
            else               rdata <= {{BYTE_W{1'b0}}, din[DATA_W-1:BYTE_W]};
        end
    end
endmodule

// File: rtl/ext_area_bus_ctrl.sv
// Area-based external bus controller, top level. It accepts one request at a time, decodes the
// area from the top address bits, drives the chip selects and strobes from the sequencer state,
// and returns a one-clock done pulse. Assumes a single requester and one bus state per clock.
module ext_area_bus_ctrl
    import bac_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int N_AREAS = 8,
    localparam int AREA_W = $clog2(N_AREAS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    input  logic                        req_word,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic [DATA_W-1:0]           req_rdata,
    output logic                        req_done,
    input  logic [N_AREAS-1:0]          cfg_wide,
    input  logic [N_AREAS-1:0]          cfg_three,
    input  logic [N_AREAS*WCOUNT_W-1:0] cfg_waits,
    input  logic [N_AREAS-1:0]          cfg_ext,
    input  logic [N_AREAS-1:0]          cfg_rd_late,
    output logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_din,
    output logic [DATA_W-1:0]           bus_dout,
    output logic                        bus_doe,
    output logic [N_AREAS-1:0]          bus_cs_n,
    output logic                        bus_rd_n,
    output logic                        bus_wrh_n,
    output logic                        bus_wrl_n,
    input  logic                        bus_wait_n
);
    logic [AREA_W-1:0] area_in, area_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q, word_q;
    logic              accept, busy, access, wr_state;
    logic              rd_hold;
    area_cfg_t         sel_cfg, cfg_q;
    bus_state_t        state;
    logic              split_q, phase, cycle_end, use_hi, use_lo;

    assign area_in = req_addr[ADDR_W-1 -: AREA_W];

    bac_area_sel #(.N_AREAS(N_AREAS)) u_sel (
        .area_idx   (area_in),
        .cfg_wide   (cfg_wide),
        .cfg_three  (cfg_three),
        .cfg_waits  (cfg_waits),
        .cfg_ext    (cfg_ext),
        .cfg_rd_late(cfg_rd_late),
        .sel_cfg    (sel_cfg)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            area_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            word_q  <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            area_q  <= area_in;
            wdata_q <= req_wdata;
            write_q <= req_write;
            word_q  <= req_word;
        end
    end

    bac_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_word(req_word),
        .cfg_in    (sel_cfg),
        .wait_n    (bus_wait_n),
        .state     (state),
        .cfg_q     (cfg_q),
        .split_q   (split_q),
        .phase     (phase),
        .cycle_end (cycle_end),
        .done      (req_done)
    );

    bac_lanes #(.ADDR_W(ADDR_W)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_q  (addr_q),
        .word_q  (word_q),
        .wide    (cfg_q.wide),
        .split   (split_q),
        .phase   (phase),
        .wdata_q (wdata_q),
        .din     (bus_din),
        .sample  (cycle_end && !write_q),
        .eff_addr(bus_addr),
        .dout    (bus_dout),
        .use_hi  (use_hi),
        .use_lo  (use_lo),
        .rdata   (req_rdata)
    );

    assign busy     = (state != ST_IDLE);
    assign access   = (state == ST_T1) || (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    assign wr_state = write_q && ((state == ST_T2) || (state == ST_TW));

    // One chip select per area, low for the whole access to that area.
    for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
        assign bus_cs_n[g] = !(busy && (area_q == AREA_W'(g)));
    end

    // Read strobe hold for one state after a read in an area with the late option.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_hold <= 1'b0;
        else        rd_hold <= cycle_end && !write_q && cfg_q.rd_late;
    end

    assign bus_rd_n  = !((access && !write_q) || rd_hold);
    assign bus_wrh_n = !(wr_state && use_hi);
    assign bus_wrl_n = !(wr_state && use_lo);
    assign bus_doe   = write_q && busy;
endmodule

// File: rtl/bac_checker.sv
// Protocol checker for the bus controller, attached to every instance of the top module.
// Relates ports only; all properties are reset-qualified.
module bac_checker #(
    parameter int N_AREAS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               req_done,
    input logic [N_AREAS-1:0] bus_cs_n,
    input logic               bus_rd_n,
    input logic               bus_wrh_n,
    input logic               bus_wrl_n,
    input logic               bus_doe
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_cs_n) <= 1); // R2
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&bus_cs_n)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R11
    AST_WR_WITH_DOE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wrh_n || !bus_wrl_n) |-> (bus_doe && !(&bus_cs_n))); // R8
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && (!bus_wrh_n || !bus_wrl_n))); // R8
    AST_DOE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !(&bus_cs_n)); // R8
endmodule

bind ext_area_bus_ctrl bac_checker #(.N_AREAS(N_AREAS)) u_bac_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .req_done (req_done),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wrh_n(bus_wrh_n),
    .bus_wrl_n(bus_wrl_n),
    .bus_doe  (bus_doe)
);

// File: tb/test_ext_area_bus_ctrl.sv
`timescale 1ns/1ps
// Directed bench for the area-based external bus controller.
module test_ext_area_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] req_rdata;
    logic        req_done;
    logic [7:0]  cfg_wide = '0, cfg_three = '0, cfg_ext = '0, cfg_rd_late = '0;
    logic [15:0] cfg_waits = '0;
    logic [23:0] bus_addr;
    logic [15:0] bus_din, bus_dout;
    logic        bus_doe, bus_rd_n, bus_wrh_n, bus_wrl_n;
    logic [7:0]  bus_cs_n;
    logic        bus_wait_n = 1'b1;

    int n_checks = 0, n_fail = 0;

    // Monitor state
    int          n_cs, n_wrh, n_wrl, n_doe, n_done;
    logic [7:0]  cs_or, dh_first, dh_last, dl;
    logic        multi, cs_prev, rd_first, rd_last, rd_after, seen_wrh;
    logic [23:0] addr_first, addr_last;
    logic        wait_low = 1'b0;
    int          rel_at = 0;

    always #2 clk = ~clk;

    // External memory model: high byte = low address byte, low byte = its inverse.
    assign bus_din = {bus_addr[7:0], ~bus_addr[7:0]};

    ext_area_bus_ctrl i_ext_area_bus_ctrl (.*);

    task automatic clear_mon();
        n_cs = 0; n_wrh = 0; n_wrl = 0; n_doe = 0; n_done = 0;
        cs_or = '0; multi = 0; cs_prev = 0; rd_first = 1; rd_last = 1; rd_after = 1;
        seen_wrh = 0; dh_first = '0; dh_last = '0; dl = '0; addr_first = '0; addr_last = '0;
    endtask

    // Samples the bus in the middle of each state.
    always @(negedge clk) begin
        if (~bus_cs_n != 8'h00) begin
            n_cs++;
            if ($countones(~bus_cs_n) > 1) multi = 1;
            cs_or = cs_or | ~bus_cs_n;
            if (!cs_prev) begin rd_first = bus_rd_n; addr_first = bus_addr; end
            rd_last = bus_rd_n;
            addr_last = bus_addr;
            if (bus_doe) n_doe++;
            if (!bus_wrh_n) begin
                n_wrh++;
                if (!seen_wrh) dh_first = bus_dout[15:8];
                dh_last = bus_dout[15:8];
                seen_wrh = 1;
            end
            if (!bus_wrl_n) begin n_wrl++; dl = bus_dout[7:0]; end
        end else if (cs_prev) begin
            rd_after = bus_rd_n;
        end
        if (req_done) n_done++;
        cs_prev = (~bus_cs_n != 8'h00);
    end

    // Drives the external wait input: low when requested, released after rel_at chip-select states.
    always @(negedge clk) begin
        #1;
        bus_wait_n = !(wait_low && !(rel_at != 0 && n_cs >= rel_at));
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_area(input int a, input logic wide, input logic three, input logic [1:0] w,
                            input logic ext, input logic late);
        cfg_wide[a] = wide; cfg_three[a] = three; cfg_waits[a*2 +: 2] = w;
        cfg_ext[a] = ext; cfg_rd_late[a] = late;
    endtask

    // Issues one request and waits for its completion plus a few idle states.
    task automatic acc(input logic [23:0] a, input logic wr, input logic wd, input logic [15:0] d);
        @(negedge clk); #1;
        clear_mon();
        req_addr = a; req_write = wr; req_word = wd; req_wdata = d;
        chk("R11 ready before request", req_ready, 1);
        req_valid = 1;
        @(negedge clk); #1;
        req_valid = 0;
        chk("R11 ready low while busy", req_ready, 0);
        for (int k = 0; k < 200 && n_done == 0; k++) begin
            @(negedge clk); #1;
        end
        if (n_done == 0) chk("R11 watchdog done", 0, 1);
        repeat (3) begin @(negedge clk); #1; end
        chk("R11 single done pulse", n_done, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs idle", bus_cs_n, 8'hFF);
        chk("R1 strobes idle", {bus_rd_n, bus_wrh_n, bus_wrl_n}, 3'b111);
        chk("R1 doe/done", {bus_doe, req_done}, 2'b00);
        chk("R1 ready", req_ready, 1);
    endtask

    task automatic t_two_state();
        set_area(2, 1, 0, 2'd3, 0, 0);
        acc(24'h400010, 0, 1, 0);
        chk("R3 two-state length", n_cs, 2);
        chk("R2 area 2 select", cs_or, 8'h04);
        chk("R2 one select", multi, 0);
        chk("R3 word read data", req_rdata, 16'h10EF);
        wait_low = 1; rel_at = 0;
        acc(24'h400020, 0, 1, 0);
        wait_low = 0;
        chk("R3 wait ignored", n_cs, 2);
    endtask

    task automatic t_three_state();
        set_area(5, 1, 1, 2'd2, 0, 0);
        acc(24'hA00022, 0, 1, 0);
        chk("R4 three-state plus 2 waits", n_cs, 5);
        chk("R2 area 5 select", cs_or, 8'h20);
        chk("R4 read data", req_rdata, 16'h22DD);
        set_area(5, 1, 1, 2'd0, 0, 0);
        wait_low = 1; rel_at = 4;
        acc(24'hA00030, 0, 1, 0);
        wait_low = 0; rel_at = 0;
        chk("R5 wait pin adds two states", n_cs, 5);
        set_area(5, 1, 1, 2'd1, 0, 0);
        wait_low = 1; rel_at = 4;
        acc(24'hA00030, 0, 1, 0);
        wait_low = 0; rel_at = 0;
        chk("R5 sampled after programmed wait", n_cs, 5);
    endtask

    task automatic t_extension();
        set_area(1, 1, 0, 2'd0, 1, 0);
        acc(24'h200004, 0, 0, 0);
        chk("R6 extension length", n_cs, 4);
        chk("R6 rd high in leading state", rd_first, 1);
        chk("R6 rd high in trailing state", rd_last, 1);
        chk("R10 even byte read", req_rdata, 16'h0004);
    endtask

    task automatic t_rd_late();
        set_area(3, 1, 0, 2'd0, 0, 1);
        acc(24'h600008, 0, 1, 0);
        chk("R7 rd held after cycle", rd_after, 0);
        set_area(3, 1, 0, 2'd0, 0, 0);
        acc(24'h600008, 0, 1, 0);
        chk("R7 rd released without option", rd_after, 1);
    endtask

    task automatic t_byte_lanes();
        set_area(4, 1, 1, 2'd1, 0, 0);
        acc(24'h800003, 1, 0, 16'h005A);
        chk("R8 write cycle length", n_cs, 4);
        chk("R8 strobe states", n_wrl, 2);
        chk("R8 doe whole cycle", n_doe, 4);
        chk("R10 odd byte no high strobe", n_wrh, 0);
        chk("R10 odd byte low lane", dl, 8'h5A);
        acc(24'h800002, 1, 0, 16'h003C);
        chk("R10 even byte high strobe", n_wrh, 2);
        chk("R10 even byte no low strobe", n_wrl, 0);
        chk("R10 even byte high lane", dh_last, 8'h3C);
        acc(24'h800007, 0, 0, 0);
        chk("R10 odd byte read", req_rdata, 16'h00F8);
    endtask

    task automatic t_split();
        set_area(6, 0, 0, 2'd0, 0, 0);
        acc(24'hC00010, 0, 1, 0);
        chk("R9 two byte cycles", n_cs, 4);
        chk("R9 assembled read", req_rdata, 16'h1011);
        chk("R9 even address first", addr_first, 24'hC00010);
        chk("R9 odd address second", addr_last, 24'hC00011);
        acc(24'hC00020, 1, 1, 16'hBEEF);
        chk("R9 upper byte first", dh_first, 8'hBE);
        chk("R9 lower byte second", dh_last, 8'hEF);
        chk("R9 high strobe per byte", n_wrh, 2);
        chk("R9 no low strobe", n_wrl, 0);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1;
        t_reset();
        t_two_state();
        t_three_state();
        t_extension();
        t_rd_late();
        t_byte_lanes();
        t_split();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++; n_fail++;
        $display("FAIL R11 global watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule